// File: doc/BRIEF.md
# USB Host Interrupt Controller

This block collects the interrupt sources of a small embedded USB host and drives one level-sensitive interrupt request to an external CPU. Single-cycle event pulses arrive from two host transfer channels (A and B), from a frame-start timer, from a device insert/remove detector, and from separate device-detect and resume-detect indications. Each event latches a bit in a status register. A per-bit enable register decides which latched bits reach the request line. Enables never change how status bits are set or cleared.

The CPU reaches the block through an 8-bit register port with three registers. The control register holds a frame-timer enable and a resume mode select. The mode select decides which detector feeds the shared status and enable position. The CPU clears status bits by writing ones to them. A done event on either channel also sends a one-cycle strobe, so that the channel's packet-status logic elsewhere updates its record.

Top module: `usbh_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the control, enable and status registers are 0. `irq`, both update strobes and every read value are 0.
- R2: The enable register is at address 0x06. Only bits 0 (channel A done), 1 (channel B done), 4 (frame timer), 5 (insert/remove) and 6 (detect/resume) can be written. Bits 7, 3 and 2 ignore writes and read as 0.
- R3: The control register is at address 0x05. Bit 0 is the frame-timer enable and bit 6 is the resume mode select. All other bits ignore writes and read as 0.
- R4: The status register is at address 0x0D. A channel A done pulse sets bit 0, a channel B done pulse sets bit 1, and an insert/remove pulse sets bit 5, whatever the enable register holds. Bits 7, 3 and 2 always read as 0.
- R5: When control bit 6 is 1, a resume pulse sets status bit 6 and a device-detect pulse is ignored. When control bit 6 is 0, the roles are swapped.
- R6: A frame-timer pulse sets status bit 4 only while control bit 0 is 1. While control bit 0 is 0, the pulse is ignored.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: `irq` is registered. It is 1 in the cycle after any status bit and its enable bit are both 1, and it falls one cycle after that is no longer true.
- R9: `a_pkt_upd` and `b_pkt_upd` pulse for exactly one cycle, one clock after a done pulse on their channel.
- R10: Reads of any other address return 0, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_a_done | input | 1 | Channel A transfer done pulse |
| ev_b_done | input | 1 | Channel B transfer done pulse |
| ev_frame_tick | input | 1 | Frame-start timer pulse |
| ev_ins_rem | input | 1 | Device inserted/removed pulse |
| ev_dev_detect | input | 1 | Device-detect pulse |
| ev_resume | input | 1 | Resume-detect pulse |
| cpu_addr | input | 8 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr (combinational) |
| irq | output | 1 | Level interrupt request |
| a_pkt_upd | output | 1 | Channel A packet-status update strobe |
| b_pkt_upd | output | 1 | Channel B packet-status update strobe |

## Verification
An event pulse and a CPU write-one-to-clear of the same status bit can land in the same cycle. The event must win. The bench provokes this in a directed case and also through random stimulus, where event pulses and status writes are drawn independently every cycle. A reference model in the bench applies the clear first and the set after it, then compares the status read-back and the registered request against what the model predicts.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    localparam logic [AW-1:0] ADDR_CTRL = 8'h05;
    localparam logic [AW-1:0] ADDR_ENA  = 8'h06;
    localparam logic [AW-1:0] ADDR_STAT = 8'h0D;

    localparam int B_A_DONE = 0;
    localparam int B_B_DONE = 1;
    localparam int B_FRAME  = 4;
    localparam int B_INSREM = 5;
    localparam int B_DETRES = 6;

    localparam int C_TIMER  = 0;
    localparam int C_RESUME = 6;

    localparam logic [DW-1:0] IRQ_MASK  = 8'h73;
    localparam logic [DW-1:0] CTRL_MASK = 8'h41;

    typedef struct packed {
        logic a_done;
        logic b_done;
        logic frame_tick;
        logic ins_rem;
        logic dev_detect;
        logic resume;
    } irq_events_t;

    typedef struct packed {
        logic resume_mode;
        logic timer_en;
    } ctrl_t;

    function automatic logic [DW-1:0] event_vector(irq_events_t ev, ctrl_t c);
        logic [DW-1:0] v;
        v = '0;
        v[B_A_DONE] = ev.a_done;
        v[B_B_DONE] = ev.b_done;
        v[B_FRAME]  = ev.frame_tick & c.timer_en;
        v[B_INSREM] = ev.ins_rem;
        v[B_DETRES] = c.resume_mode ? ev.resume : ev.dev_detect;
        return v;
    endfunction

    function automatic logic [DW-1:0] ctrl_to_bits(ctrl_t c);
        logic [DW-1:0] v;
        v = '0;
        v[C_TIMER]  = c.timer_en;
        v[C_RESUME] = c.resume_mode;
        return v;
    endfunction
endpackage

// File: rtl/usbh_irq_cfg.sv
module usbh_irq_cfg
    import usbh_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_ena,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl_q,
    output logic [DW-1:0] ena_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ena_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.timer_en    <= wdata[C_TIMER];
                ctrl_q.resume_mode <= wdata[C_RESUME];
            end
            if (wr_ena) ena_q <= wdata & IRQ_MASK;
        end
    end

    AST_ENA_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ena_q & ~IRQ_MASK) == '0);                                         // R2
    AST_ENA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_ena |=> $stable(ena_q));                                        // R10
endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status
    import usbh_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] set_vec,
    input  logic          wr_stat,
    input  logic [DW-1:0] wdata,
    input  logic          timer_en,
    output logic [DW-1:0] stat_q
);
    logic [DW-1:0] clr_vec;
    assign clr_vec = wr_stat ? (wdata & IRQ_MASK) : '0;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= ((stat_q & ~clr_vec) | set_vec) & IRQ_MASK;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec))); // R7
    AST_RSVD_STAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (stat_q & ~IRQ_MASK) == '0);                                        // R4
    AST_FRAME_GATED: assert property (@(posedge clk) disable iff (rst)
        (!timer_en && !stat_q[B_FRAME]) |=> !stat_q[B_FRAME]);              // R6
    AST_CLR_ONLY_BY_WR: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));          // R7
endmodule

// File: rtl/usbh_irq_req.sv
module usbh_irq_req
    import usbh_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] stat_q,
    input  logic [DW-1:0] ena_q,
    input  irq_events_t   ev,
    output logic          irq,
    output logic          a_upd,
    output logic          b_upd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq   <= 1'b0;
            a_upd <= 1'b0;
            b_upd <= 1'b0;
        end else begin
            irq   <= |(stat_q & ena_q);
            a_upd <= ev.a_done;
            b_upd <= ev.b_done;
        end
    end

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past((stat_q & ena_q) != '0));                     // R8
    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past((stat_q & ena_q) == '0));                     // R8
    AST_A_UPD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        ev.a_done |=> a_upd);                                               // R9
    AST_B_UPD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        ev.b_done |=> b_upd);                                               // R9
endmodule

// File: rtl/usbh_irq_ctrl.sv
module usbh_irq_ctrl
    import usbh_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_a_done,
    input  logic          ev_b_done,
    input  logic          ev_frame_tick,
    input  logic          ev_ins_rem,
    input  logic          ev_dev_detect,
    input  logic          ev_resume,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          irq,
    output logic          a_pkt_upd,
    output logic          b_pkt_upd
);
    irq_events_t   ev;
    ctrl_t         ctrl_q;
    logic [DW-1:0] ena_q;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] set_vec;

    assign ev = '{a_done: ev_a_done, b_done: ev_b_done, frame_tick: ev_frame_tick,
                  ins_rem: ev_ins_rem, dev_detect: ev_dev_detect, resume: ev_resume};
    assign set_vec = event_vector(ev, ctrl_q);

    usbh_irq_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (cpu_wr && cpu_addr == ADDR_CTRL),
        .wr_ena  (cpu_wr && cpu_addr == ADDR_ENA),
        .wdata   (cpu_wdata),
        .ctrl_q  (ctrl_q),
        .ena_q   (ena_q)
    );

    usbh_irq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .wr_stat  (cpu_wr && cpu_addr == ADDR_STAT),
        .wdata    (cpu_wdata),
        .timer_en (ctrl_q.timer_en),
        .stat_q   (stat_q)
    );

    usbh_irq_req u_req (
        .clk    (clk),
        .rst    (rst),
        .stat_q (stat_q),
        .ena_q  (ena_q),
        .ev     (ev),
        .irq    (irq),
        .a_upd  (a_pkt_upd),
        .b_upd  (b_pkt_upd)
    );

    always_comb begin
        unique case (cpu_addr)
            ADDR_CTRL: cpu_rdata = ctrl_to_bits(ctrl_q);
            ADDR_ENA:  cpu_rdata = ena_q;
            ADDR_STAT: cpu_rdata = stat_q;
            default:   cpu_rdata = '0;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq && stat_q == '0 && ena_q == '0));                     // R1
    AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (a_pkt_upd && !ev_a_done) |=> !a_pkt_upd);                          // R9
endmodule

// File: tb/usbh_irq_ctrl_tb_top.sv
module usbh_irq_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic ev_a, ev_b, ev_fr, ev_ir, ev_dd, ev_rs;
    logic [7:0] addr, wdata, rdata;
    logic wr, irq, a_upd, b_upd;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_ctrl, m_ena, m_stat;
    logic m_irq, m_a_upd, m_b_upd;

    always #10 clk = ~clk;

    usbh_irq_ctrl dut_i (
        .clk(clk), .rst(rst),
        .ev_a_done(ev_a), .ev_b_done(ev_b), .ev_frame_tick(ev_fr),
        .ev_ins_rem(ev_ir), .ev_dev_detect(ev_dd), .ev_resume(ev_rs),
        .cpu_addr(addr), .cpu_wr(wr), .cpu_wdata(wdata), .cpu_rdata(rdata),
        .irq(irq), .a_pkt_upd(a_upd), .b_pkt_upd(b_upd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h05:   return m_ctrl;
            8'h06:   return m_ena;
            8'h0D:   return m_stat;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'h05:   return "R3 ctrl read";
            8'h06:   return "R2 enable read";
            8'h0D:   return "R4/R5/R6/R7 status read";
            default: return "R10 unmapped read";
        endcase
    endfunction

    // ev bits: [5]=A done [4]=B done [3]=frame [2]=ins/rem [1]=detect [0]=resume
    task automatic cyc(input logic [5:0] ev, input logic w, input logic [7:0] a,
                       input logic [7:0] d, input string note);
        logic [7:0] setv, clrv;
        @(negedge clk);
        {ev_a, ev_b, ev_fr, ev_ir, ev_dd, ev_rs} = ev;
        wr = w; addr = a; wdata = d;
        @(posedge clk);
        setv = 8'h00;
        setv[0] = ev[5];
        setv[1] = ev[4];
        setv[4] = ev[3] & m_ctrl[0];
        setv[5] = ev[2];
        setv[6] = m_ctrl[6] ? ev[0] : ev[1];
        clrv = (w && a == 8'h0D) ? (d & 8'h73) : 8'h00;
        m_irq   = |(m_stat & m_ena);
        m_a_upd = ev[5];
        m_b_upd = ev[4];
        m_stat  = (m_stat & ~clrv) | setv;
        if (w && a == 8'h05) m_ctrl = d & 8'h41;
        if (w && a == 8'h06) m_ena  = d & 8'h73;
        #5;
        chk({"R8 irq ", note}, {7'd0, irq}, {7'd0, m_irq});
        chk({"R9 A upd ", note}, {7'd0, a_upd}, {7'd0, m_a_upd});
        chk({"R9 B upd ", note}, {7'd0, b_upd}, {7'd0, m_b_upd});
        chk({read_tag(a), " ", note}, rdata, model_read(a));
    endtask

    task automatic rd(input logic [7:0] a, input string note);
        cyc(6'b0, 1'b0, a, 8'h00, note);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1;
        {ev_a, ev_b, ev_fr, ev_ir, ev_dd, ev_rs} = '0;
        wr = 0; addr = 8'h0D; wdata = 0;
        m_ctrl = 0; m_ena = 0; m_stat = 0; m_irq = 0; m_a_upd = 0; m_b_upd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        chk("R1 reset status", rdata, 8'h00);
        chk("R1 reset upd", {6'd0, a_upd, b_upd}, 8'h00);

        // R2: reserved enable bits
        cyc(6'b0, 1, 8'h06, 8'hFF, "R2 write all ones");
        rd(8'h06, "R2 readback 0x73");
        chk("R2 enable value", rdata, 8'h73);
        // R3: control reserved bits
        cyc(6'b0, 1, 8'h05, 8'hBE, "R3 write");
        rd(8'h05, "R3 readback");
        chk("R3 ctrl value", rdata, 8'h00);
        // R4: events set status with enable off
        cyc(6'b0, 1, 8'h06, 8'h00, "R4 enables off");
        cyc(6'b100100, 0, 8'h0D, 8'h00, "R4 A and ins/rem");
        chk("R4 status A+insrem", rdata, 8'h21);
        rd(8'h0D, "R8 no irq while masked");
        chk("R8 masked irq low", {7'd0, irq}, 8'h00);
        // R6: frame tick ignored while timer off
        cyc(6'b001000, 0, 8'h0D, 8'h00, "R6 tick timer off");
        chk("R6 tick ignored", rdata, 8'h21);
        // R5: detect mode (ctrl bit6=0): resume ignored
        cyc(6'b000001, 0, 8'h0D, 8'h00, "R5 resume ignored");
        chk("R5 resume ignored in detect mode", rdata, 8'h21);
        cyc(6'b000010, 0, 8'h0D, 8'h00, "R5 detect sets");
        chk("R5 detect sets bit6", rdata, 8'h61);
        // R7: clear with 1, 0 no effect, set wins
        cyc(6'b0, 1, 8'h0D, 8'h40, "R7 clear bit6");
        chk("R7 bit6 cleared", rdata, 8'h21);
        cyc(6'b100000, 1, 8'h0D, 8'h01, "R7 set wins");
        chk("R7 set wins over clear", rdata, 8'h21);
        cyc(6'b0, 1, 8'h0D, 8'h00, "R7 write zero");
        chk("R7 zero write no effect", rdata, 8'h21);
        // R8: irq one cycle after enable
        cyc(6'b0, 1, 8'h06, 8'h20, "R8 enable insrem");
        chk("R8 irq not yet", {7'd0, irq}, 8'h00);
        rd(8'h0D, "R8 irq up");
        chk("R8 irq high", {7'd0, irq}, 8'h01);
        // R10: unmapped write changes nothing
        cyc(6'b0, 1, 8'h07, 8'hFF, "R10 unmapped write");
        rd(8'h06, "R10 enable intact");
        chk("R10 enable unchanged", rdata, 8'h20);
        // R5 resume mode, R6 timer on
        cyc(6'b0, 1, 8'h05, 8'h41, "R3 timer+resume");
        cyc(6'b001011, 0, 8'h0D, 8'h00, "R5/R6 resume+tick");
        chk("R5/R6 resume and tick set", rdata, 8'h71);

        for (int i = 0; i < 3000; i++) begin
            logic [5:0] ev;
            logic [7:0] a, d;
            logic w;
            int sel;
            ev  = 6'($urandom) & 6'($urandom);
            w   = ($urandom % 3) == 0;
            sel = $urandom % 5;
            a   = (sel == 0) ? 8'h05 : (sel == 1) ? 8'h06 :
                  (sel == 4) ? 8'($urandom) : 8'h0D;
            d   = 8'($urandom);
            cyc(ev, w, a, d, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule